// File: doc/BRIEF.md
# Floating-Point Load/Store Address and Sequencing Unit

This unit sits between the decode stage and a word-wide memory port and carries out floating-point loads and stores. For each accepted request it forms the effective address from an integer base value plus either a sign-extended 13-bit offset or a second integer value. A single-word operation becomes one memory transfer. A paired (doubleword) operation becomes two back-to-back word transfers: the low address first, then the address plus four.

Loaded words go straight to the floating-point register file write port in the cycle their handshake completes. Paired operations are screened before any transfer starts. An address that is not a multiple of eight raises a misalignment trap. An odd destination register raises an illegal-instruction trap. In both cases no memory request is issued and no register is written.

The pipeline sees `req_ready` low from the cycle after acceptance until the last word handshake of the operation completes.

Top module: `fpls_unit`

## Requirements
- R1: After reset, or when reset is raised in the middle of an operation, `req_ready` is 1 and `mem_valid`, `fpw_en`, `trap_misalign` and `trap_illegal` are 0.
- R2: With `req_imm_sel`=1 the address is `req_base` plus `req_imm` sign-extended from its bit 12 to 32 bits.
- R3: With `req_imm_sel`=0 the address is `req_base` plus `req_index`.
- R4: A single load (`req_op`=2'b00) makes one read transfer. In its handshake cycle `fpw_en`=1, `fpw_idx`=rd and `fpw_data`=`mem_rdata`. The low address bits are not checked.
- R5: A single store (`req_op`=2'b10) makes one write transfer with `mem_we`=1 and `mem_wdata`=`req_st_lo`. `fpw_en` stays 0.
- R6: A paired load (`req_op`=2'b01) makes two read transfers, at EA and then EA+4. It writes register rd from the first and register rd+1 from the second.
- R7: A paired store (`req_op`=2'b11) writes `req_st_lo` at EA and then `req_st_hi` at EA+4.
- R8: A paired operation whose EA has any of bits [2:0] set pulses `trap_misalign` for one cycle, in the cycle after acceptance. It issues no memory transfer and no register write.
- R9: A paired operation with an 8-byte-aligned EA and an odd rd pulses `trap_illegal` for one cycle, in the cycle after acceptance. It issues no transfer and no register write.
- R10: When a paired operation is both misaligned and has an odd rd, only `trap_misalign` is raised.
- R11: `req_ready` is 0 while a transfer is pending. While `mem_valid`=1 and `mem_ready`=0, the address, write enable and write data are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_op | input | 2 | Bit 0: paired, bit 1: store |
| req_rd | input | 5 | FP register index |
| req_base | input | 32 | First integer operand |
| req_index | input | 32 | Second integer operand |
| req_imm_sel | input | 1 | 1 selects the immediate offset |
| req_imm | input | 13 | Signed offset |
| req_st_lo | input | 32 | Store data for register rd |
| req_st_hi | input | 32 | Store data for register rd+1 |
| mem_valid | output | 1 | Word transfer request |
| mem_ready | input | 1 | Memory accepts and completes the transfer |
| mem_addr | output | 32 | Byte address of the word |
| mem_we | output | 1 | 1 for write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| fpw_en | output | 1 | FP register write enable |
| fpw_idx | output | 5 | FP register index written |
| fpw_data | output | 32 | FP register write data |
| trap_misalign | output | 1 | Paired access misaligned |
| trap_illegal | output | 1 | Paired access with odd register |

## Verification
The hardest cases to reach are a paired transfer whose second beat is stalled, and a trap raised while the request port is idle again. The first needs an aligned paired request with `mem_ready` held low for several cycles on each beat. The second needs the bench to sample the trap pulse exactly one cycle after acceptance. Table rows carry a per-row stall count and an expected trap code. This makes the bench check that the held address has not moved and that nothing reaches the memory or the register port on trapped rows. These rows include a negative offset that makes the address both misaligned and paired with an odd register, and a paired access at the top of the address space.

// File: rtl/fpls_pkg.sv
package fpls_pkg;
    localparam int unsigned FPLS_AW         = 32;
    localparam int unsigned FPLS_DW         = 32;
    localparam int unsigned FPLS_RW         = 5;
    localparam int unsigned FPLS_IW         = 13;
    localparam int unsigned FPLS_PAIR_ALIGN = 3;
    localparam int unsigned FPLS_WORD_BYTES = FPLS_DW / 8;

    typedef logic [FPLS_AW-1:0] fpls_addr_t;
    typedef logic [FPLS_DW-1:0] fpls_data_t;
    typedef logic [FPLS_RW-1:0] fpls_ridx_t;

    // bit 0: paired, bit 1: store
    typedef enum logic [1:0] {
        OP_LD_ONE  = 2'b00,
        OP_LD_PAIR = 2'b01,
        OP_ST_ONE  = 2'b10,
        OP_ST_PAIR = 2'b11
    } fpls_op_e;

    typedef enum logic [1:0] {
        TR_NONE     = 2'd0,
        TR_MISALIGN = 2'd1,
        TR_ILLEGAL  = 2'd2
    } fpls_trap_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_BEAT0 = 2'd1,
        SQ_BEAT1 = 2'd2
    } fpls_state_e;

    typedef struct packed {
        fpls_op_e   op;
        fpls_ridx_t rd;
        fpls_addr_t ea;
        fpls_data_t wd0;
        fpls_data_t wd1;
    } fpls_job_t;

    function automatic logic op_is_pair(fpls_op_e o);
        return o[0];
    endfunction

    function automatic logic op_is_store(fpls_op_e o);
        return o[1];
    endfunction

    function automatic fpls_addr_t sext_imm(logic [FPLS_IW-1:0] i);
        return {{(FPLS_AW-FPLS_IW){i[FPLS_IW-1]}}, i};
    endfunction
endpackage

// File: rtl/fpls_ea_gen.sv
module fpls_ea_gen
    import fpls_pkg::*;
(
    input  fpls_addr_t         base,
    input  fpls_addr_t         index,
    input  logic               imm_sel,
    input  logic [FPLS_IW-1:0] imm,
    output fpls_addr_t         ea
);
    fpls_addr_t offset;

    always_comb begin
        offset = imm_sel ? sext_imm(imm) : index;
        ea     = base + offset;
    end
endmodule

// File: rtl/fpls_screen.sv
module fpls_screen
    import fpls_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = FPLS_PAIR_ALIGN
) (
    input  fpls_op_e              op,
    input  logic                  rd_lsb,
    input  logic [ALIGN_BITS-1:0] ea_low,
    output fpls_trap_e            verdict
);
    always_comb begin
        verdict = TR_NONE;
        if (op_is_pair(op)) begin
            if (|ea_low)     verdict = TR_MISALIGN;   // alignment has priority
            else if (rd_lsb) verdict = TR_ILLEGAL;
        end
    end
endmodule

// File: rtl/fpls_seq.sv
module fpls_seq
    import fpls_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  fpls_job_t  job_in,
    input  fpls_trap_e verdict,
    output logic       busy,
    output logic       mem_valid,
    input  logic       mem_ready,
    output fpls_addr_t mem_addr,
    output logic       mem_we,
    output fpls_data_t mem_wdata,
    input  fpls_data_t mem_rdata,
    output logic       fpw_en,
    output fpls_ridx_t fpw_idx,
    output fpls_data_t fpw_data,
    output logic       trap_misalign,
    output logic       trap_illegal
);
    fpls_state_e state;
    fpls_job_t   job;
    logic        second;
    logic        hs;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= SQ_IDLE;
            job           <= '0;
            trap_misalign <= 1'b0;
            trap_illegal  <= 1'b0;
        end else begin
            trap_misalign <= accept && (verdict == TR_MISALIGN);
            trap_illegal  <= accept && (verdict == TR_ILLEGAL);
            case (state)
                SQ_IDLE: begin
                    if (accept && verdict == TR_NONE) begin
                        job   <= job_in;
                        state <= SQ_BEAT0;
                    end
                end
                SQ_BEAT0: begin
                    if (mem_ready) state <= op_is_pair(job.op) ? SQ_BEAT1 : SQ_IDLE;
                end
                SQ_BEAT1: begin
                    if (mem_ready) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != SQ_IDLE);
        second    = (state == SQ_BEAT1);
        mem_valid = busy;
        hs        = mem_valid && mem_ready;
        // paired accesses are 8-byte aligned, so the second word sets bit 2
        mem_addr  = second ? (job.ea | FPLS_AW'(FPLS_WORD_BYTES)) : job.ea;
        mem_we    = op_is_store(job.op);
        mem_wdata = second ? job.wd1 : job.wd0;
        fpw_en    = hs && !op_is_store(job.op);
        fpw_idx   = job.rd | {{(FPLS_RW-1){1'b0}}, second};
        fpw_data  = mem_rdata;
    end
endmodule

// File: rtl/fpls_unit.sv
module fpls_unit
    import fpls_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = FPLS_PAIR_ALIGN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [FPLS_RW-1:0] req_rd,
    input  logic [FPLS_AW-1:0] req_base,
    input  logic [FPLS_AW-1:0] req_index,
    input  logic               req_imm_sel,
    input  logic [FPLS_IW-1:0] req_imm,
    input  logic [FPLS_DW-1:0] req_st_lo,
    input  logic [FPLS_DW-1:0] req_st_hi,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [FPLS_AW-1:0] mem_addr,
    output logic               mem_we,
    output logic [FPLS_DW-1:0] mem_wdata,
    input  logic [FPLS_DW-1:0] mem_rdata,
    output logic               fpw_en,
    output logic [FPLS_RW-1:0] fpw_idx,
    output logic [FPLS_DW-1:0] fpw_data,
    output logic               trap_misalign,
    output logic               trap_illegal
);
    fpls_addr_t ea;
    fpls_trap_e verdict;
    fpls_job_t  job_in;
    fpls_op_e   op;
    logic       busy;
    logic       accept;

    assign op        = fpls_op_e'(req_op);
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    fpls_ea_gen u_ea (
        .base    (req_base),
        .index   (req_index),
        .imm_sel (req_imm_sel),
        .imm     (req_imm),
        .ea      (ea)
    );

    fpls_screen #(.ALIGN_BITS(ALIGN_BITS)) u_screen (
        .op      (op),
        .rd_lsb  (req_rd[0]),
        .ea_low  (ea[ALIGN_BITS-1:0]),
        .verdict (verdict)
    );

    always_comb begin
        job_in.op  = op;
        job_in.rd  = req_rd;
        job_in.ea  = ea;
        job_in.wd0 = req_st_lo;
        job_in.wd1 = req_st_hi;
    end

    fpls_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .accept        (accept),
        .job_in        (job_in),
        .verdict       (verdict),
        .busy          (busy),
        .mem_valid     (mem_valid),
        .mem_ready     (mem_ready),
        .mem_addr      (mem_addr),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .fpw_en        (fpw_en),
        .fpw_idx       (fpw_idx),
        .fpw_data      (fpw_data),
        .trap_misalign (trap_misalign),
        .trap_illegal  (trap_illegal)
    );
endmodule

// File: rtl/fpls_chk.sv
module fpls_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic [31:0] mem_addr,
    input logic        mem_we,
    input logic [31:0] mem_wdata,
    input logic        fpw_en,
    input logic        trap_misalign,
    input logic        trap_illegal
);
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_we) && $stable(mem_wdata)));

    a_r11_busy: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> !req_ready);

    a_r8_misalign_quiet: assert property (@(posedge clk) disable iff (rst)
        trap_misalign |-> (!mem_valid && !fpw_en));

    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        trap_illegal |-> (!mem_valid && !fpw_en));

    a_r10_one_trap: assert property (@(posedge clk) disable iff (rst)
        !(trap_misalign && trap_illegal));

    a_r4_wb_on_read: assert property (@(posedge clk) disable iff (rst)
        fpw_en |-> (mem_valid && mem_ready && !mem_we));
endmodule

bind fpls_unit fpls_chk i_chk (.*);

// File: tb/test_fpls_unit.sv
module test_fpls_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_op;
    logic [4:0]  req_rd;
    logic [31:0] req_base, req_index;
    logic        req_imm_sel;
    logic [12:0] req_imm;
    logic [31:0] req_st_lo, req_st_hi;
    logic        mem_valid, mem_ready, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        fpw_en;
    logic [4:0]  fpw_idx;
    logic [31:0] fpw_data;
    logic        trap_misalign, trap_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fpls_unit i_fpls_unit (.*);

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  rd;
        logic [31:0] base;
        logic [31:0] idx;
        logic        sel;
        logic [12:0] imm;
        logic [1:0]  trap;   // 0 none, 1 misalign, 2 illegal
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 5'd3,  32'h0000_1000, 32'h0000_0024, 1'b0, 13'h0000, 2'd0, 2'd0},
        '{2'b00, 5'd7,  32'h0000_2000, 32'h0,         1'b1, 13'h1FFC, 2'd0, 2'd2},
        '{2'b10, 5'd9,  32'h0000_3001, 32'h0000_0002, 1'b0, 13'h0000, 2'd0, 2'd1},
        '{2'b01, 5'd4,  32'h0000_4000, 32'h0,         1'b1, 13'h0010, 2'd0, 2'd1},
        '{2'b11, 5'd10, 32'h0000_5000, 32'h0000_0008, 1'b0, 13'h0000, 2'd0, 2'd0},
        '{2'b01, 5'd6,  32'h0000_6000, 32'h0,         1'b1, 13'h0004, 2'd1, 2'd0},
        '{2'b11, 5'd2,  32'h0000_7002, 32'h0,         1'b0, 13'h0000, 2'd1, 2'd0},
        '{2'b01, 5'd5,  32'h0000_8000, 32'h0000_0010, 1'b0, 13'h0000, 2'd2, 2'd0},
        '{2'b11, 5'd3,  32'h0000_9000, 32'h0,         1'b1, 13'h1FF9, 2'd1, 2'd0},
        '{2'b11, 5'd30, 32'hFFFF_FFF8, 32'h0,         1'b1, 13'h0000, 2'd0, 2'd2},
        '{2'b01, 5'd0,  32'h0000_0010, 32'h0,         1'b1, 13'h1FF0, 2'd0, 2'd0}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ea_of(vec_t v);
        return v.base + (v.sel ? {{19{v.imm[12]}}, v.imm} : v.idx);
    endfunction

    task automatic run_vec(vec_t v);
        logic [31:0] ea = ea_of(v);
        logic        st = v.op[1];
        int          nb = v.op[0] ? 2 : 1;
        string       at = v.sel ? "R2" : "R3";
        @(negedge clk);
        req_op = v.op; req_rd = v.rd; req_base = v.base; req_index = v.idx;
        req_imm_sel = v.sel; req_imm = v.imm;
        req_st_lo = 32'h1111_0000 | 32'(v.rd);
        req_st_hi = 32'h2222_0000 | 32'(v.rd);
        req_valid = 1'b1;
        chk("R11 ready when idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (v.trap != 0) begin
            chk("R8/R10 trap_misalign", 32'(trap_misalign), 32'(v.trap == 2'd1));
            chk("R9 trap_illegal", 32'(trap_illegal), 32'(v.trap == 2'd2));
            chk("R8 no access on trap", 32'(mem_valid), 32'd0);
            chk("R9 no write on trap", 32'(fpw_en), 32'd0);
            @(negedge clk);
            chk("R8 trap is a pulse", 32'(trap_misalign | trap_illegal), 32'd0);
            chk("R8 still no access", 32'(mem_valid), 32'd0);
        end else begin
            for (int b = 0; b < nb; b++) begin
                logic [31:0] a = ea + 32'(4 * b);
                logic [31:0] pat = 32'hA500_0000 ^ a;
                for (int s = 0; s < int'(v.stall); s++) begin
                    chk("R11 held valid", 32'(mem_valid), 32'd1);
                    chk("R11 held addr", mem_addr, a);
                    chk("R11 busy", 32'(req_ready), 32'd0);
                    @(negedge clk);
                end
                chk("R11 busy during beat", 32'(req_ready), 32'd0);
                chk("R6/R7 beat valid", 32'(mem_valid), 32'd1);
                chk(b == 0 ? at : "R6/R7 second address", mem_addr, a);
                chk("R5/R7 direction", 32'(mem_we), 32'(st));
                if (st) chk(b == 0 ? "R5 wdata" : "R7 high wdata", mem_wdata,
                            b == 0 ? req_st_lo : req_st_hi);
                mem_ready = 1'b1;
                mem_rdata = pat;
                #1;
                chk(st ? "R5 no fp write" : "R4/R6 fp write", 32'(fpw_en), 32'(!st));
                if (!st) begin
                    chk("R6 fp index", 32'(fpw_idx), 32'(v.rd) + 32'(b));
                    chk("R4 fp data", fpw_data, pat);
                end
                @(negedge clk);
                mem_ready = 1'b0;
            end
            chk("R11 ready after last beat", 32'(req_ready), 32'd1);
            chk("R6 no extra beat", 32'(mem_valid), 32'd0);
        end
    endtask

    initial begin
        rst = 1'b1; req_valid = 0; req_op = 0; req_rd = 0; req_base = 0;
        req_index = 0; req_imm_sel = 0; req_imm = 0; req_st_lo = 0;
        req_st_hi = 0; mem_ready = 0; mem_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ready", 32'(req_ready), 32'd1);
        chk("R1 reset valid", 32'(mem_valid), 32'd0);
        chk("R1 reset traps", 32'(trap_misalign | trap_illegal | fpw_en), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // reset raised while a paired load waits on memory
        @(negedge clk);
        req_op = 2'b01; req_rd = 5'd8; req_base = 32'h0000_A000;
        req_imm_sel = 1'b0; req_index = 32'h0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 pending before reset", 32'(mem_valid), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid reset clears valid", 32'(mem_valid), 32'd0);
        chk("R1 mid reset ready", 32'(req_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 stays idle", 32'(mem_valid | fpw_en), 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule